// File: doc/BRIEF.md
# Queue Occupancy and Latency Statistics Monitor

This block sits beside the request queues of an interconnect arbiter and gathers runtime statistics about them. For each monitored queue it reports the live fill level. It also accumulates how many cycles the queue has spent empty and how many it has spent full, how many separate empty and full stretches occurred, and the longest single stretch of each kind. A shared latency unit timestamps each issued request in a small in-order store and, when the matching response returns, adds the elapsed cycles to a running total. It also keeps the response count and the worst latency seen.

Monitoring software reads the results through a word-addressed read port with one cycle of read latency. It restarts all statistics by writing to a dedicated clear address. Every statistic saturates at its largest value instead of wrapping, so a long run never reports a misleadingly small number.

Each queue is tracked by a three-state machine: `QS_MID` (neither empty nor full), `QS_EMPTY` and `QS_FULL`. At every clock edge the machine moves to the state given by the sampled flags, with empty taking priority over full. The transitions into `QS_EMPTY` (from `QS_MID` or `QS_FULL`) and into `QS_FULL` (from `QS_MID` or `QS_EMPTY`) each open a new period. Staying in a state extends the current period. Any state returns to `QS_MID` when both flags are low. A clear or a reset forces `QS_MID`.

Top module: `fifo_perf_monitor`

## Requirements
- R1: After reset every statistic reads 0 and `bus_rdata` is 0.
- R2: Reading word q*8+0 (q < NQ) returns queue q's `q_level` slice (bits q*LVL_W upward) as sampled at the read edge, zero-extended.
- R3: At each clock edge where a queue's empty flag is high, its empty-cycle total (word q*8+1) grows by 1, and its empty-period count (word q*8+2) grows by 1 when the previous edge did not see it empty, or when a clear or reset came in between.
- R4: Full time is counted in the same way in words q*8+4 (cycles) and q*8+5 (periods). An edge with both flags high counts as empty only.
- R5: Words q*8+3 and q*8+6 hold the longest single empty and full periods in cycles.
- R6: A request accepted at edge t whose response is accepted at edge t+k has latency k. Responses are matched to requests in issue order. Word NQ*8+0 holds the summed latency, NQ*8+1 the response count and NQ*8+2 the largest latency.
- R7: At most TS_DEPTH requests are outstanding. Word NQ*8+3 reads the number outstanding. A request arriving when the store is full and no response leaves in the same edge is dropped. A response with nothing outstanding is ignored. A request and a response in the same edge are both handled.
- R8: Every counter and maximum stops at 2^CNT_W-1 instead of wrapping.
- R9: A write to the all-ones address zeros all statistics at that edge, and that edge counts nothing. Queue state machines return to `QS_MID`, so an ongoing stretch starts a new period. Timestamps of outstanding requests are kept.
- R10: A read at edge t updates `bus_rdata` after that edge, and the value holds until the next read. Unmapped words (offset 7 in a queue block, offsets 4 to 7 of the latency block, and all higher words) read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_level | input | NQ*LVL_W | Fill level of each monitored queue, queue 0 in the low bits |
| q_empty | input | NQ | Empty flag per queue |
| q_full | input | NQ | Full flag per queue |
| req_fire | input | 1 | A request is issued this cycle |
| rsp_fire | input | 1 | A response arrives this cycle |
| bus_wr | input | 1 | Register write strobe; clears statistics when the address is all ones |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address for read or write |
| bus_rdata | output | CNT_W | Read data, valid one cycle after the read strobe |

## Verification
A queue state machine stuck in the wrong state shows up at the next read of that queue's period count or maximum. Periods are either missed or double-counted, and the maximum stops tracking the run length. A timestamp store whose pointers drift gives latencies that differ from the known request-to-response distances. This is visible at the first response after the fault, through the total and the maximum. The outstanding-count word exposes a bad occupancy counter directly, one cycle after it is read.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [1:0] {
        QS_MID   = 2'd0,
        QS_EMPTY = 2'd1,
        QS_FULL  = 2'd2
    } qstate_e;

    localparam int unsigned BLK_WORDS = 8;
    localparam int unsigned OFF_BITS  = 3;

endpackage

// File: rtl/fpm_queue_stats.sv
module fpm_queue_stats
    import fpm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             is_empty,
    input  logic             is_full,
    output logic [CNT_W-1:0] e_tot,
    output logic [CNT_W-1:0] e_per,
    output logic [CNT_W-1:0] e_max,
    output logic [CNT_W-1:0] f_tot,
    output logic [CNT_W-1:0] f_per,
    output logic [CNT_W-1:0] f_max
);

    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    qstate_e          st_q;
    qstate_e          st_d;
    logic             entering;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_d;

    function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
        return (v == CMAX) ? v : v + ONE;
    endfunction

    // next-state decode: empty outranks full
    always_comb begin
        if (is_empty)      st_d = QS_EMPTY;
        else if (is_full)  st_d = QS_FULL;
        else               st_d = QS_MID;
    end

    assign entering = (st_d != st_q);
    assign run_d    = entering ? ONE : bump(run_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)    st_q <= QS_MID;
        else if (clr)  st_q <= QS_MID;
        else           st_q <= st_d;
    end

    // statistics outputs
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_q <= '0;
            e_tot <= '0;
            e_per <= '0;
            e_max <= '0;
            f_tot <= '0;
            f_per <= '0;
            f_max <= '0;
        end else begin
            unique case (st_d)
                QS_EMPTY: begin
                    run_q <= run_d;
                    e_tot <= bump(e_tot);
                    if (entering)      e_per <= bump(e_per);
                    if (run_d > e_max) e_max <= run_d;
                end
                QS_FULL: begin
                    run_q <= run_d;
                    f_tot <= bump(f_tot);
                    if (entering)      f_per <= bump(f_per);
                    if (run_d > f_max) f_max <= run_d;
                end
                QS_MID: begin
                    run_q <= '0;
                end
                default: begin
                    run_q <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/fpm_latency.sv
module fpm_latency #(
    parameter int CNT_W = 16,
    parameter int DEPTH = 4,
    localparam int PW    = $clog2(DEPTH),
    localparam int OCC_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             req,
    input  logic             rsp,
    output logic [CNT_W-1:0] lat_tot,
    output logic [CNT_W-1:0] lat_cnt,
    output logic [CNT_W-1:0] lat_max,
    output logic [OCC_W-1:0] occ
);

    localparam logic [CNT_W-1:0] CMAX   = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
    localparam logic [OCC_W-1:0] OCC_LIM = OCC_W'(DEPTH);
    localparam logic [OCC_W-1:0] OCC_ONE = OCC_W'(1);
    localparam logic [PW-1:0]    PTR_ONE = PW'(1);

    logic [CNT_W-1:0] now_q;
    logic [CNT_W-1:0] stamp [DEPTH];
    logic [PW-1:0]    wp_q;
    logic [PW-1:0]    rp_q;
    logic             pop;
    logic             push;
    logic [CNT_W-1:0] lat;
    logic [CNT_W:0]   sum;

    assign pop  = rsp && (occ != '0);
    assign push = req && ((occ != OCC_LIM) || pop);
    assign lat  = now_q - stamp[rp_q];
    assign sum  = {1'b0, lat_tot} + {1'b0, lat};

    // free-running time base, wrap is harmless for latencies below 2^CNT_W
    always_ff @(posedge clk) begin
        if (!rst_n) now_q <= '0;
        else        now_q <= now_q + ONE;
    end

    // in-order timestamp store
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
            occ  <= '0;
        end else begin
            if (push) wp_q <= wp_q + PTR_ONE;
            if (pop)  rp_q <= rp_q + PTR_ONE;
            if (push && !pop)      occ <= occ + OCC_ONE;
            else if (pop && !push) occ <= occ - OCC_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (push) stamp[wp_q] <= now_q;
    end

    // latency statistics
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            lat_tot <= '0;
            lat_cnt <= '0;
            lat_max <= '0;
        end else if (pop) begin
            lat_tot <= sum[CNT_W] ? CMAX : sum[CNT_W-1:0];
            lat_cnt <= (lat_cnt == CMAX) ? lat_cnt : lat_cnt + ONE;
            if (lat > lat_max) lat_max <= lat;
        end
    end

endmodule

// File: rtl/fpm_readout.sv
module fpm_readout
    import fpm_pkg::*;
#(
    parameter int NQ     = 2,
    parameter int LVL_W  = 5,
    parameter int CNT_W  = 16,
    parameter int OCC_W  = 3,
    parameter int ADDR_W = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [NQ-1:0][LVL_W-1:0]   lvl,
    input  logic [NQ-1:0][CNT_W-1:0]   e_tot,
    input  logic [NQ-1:0][CNT_W-1:0]   e_per,
    input  logic [NQ-1:0][CNT_W-1:0]   e_max,
    input  logic [NQ-1:0][CNT_W-1:0]   f_tot,
    input  logic [NQ-1:0][CNT_W-1:0]   f_per,
    input  logic [NQ-1:0][CNT_W-1:0]   f_max,
    input  logic [CNT_W-1:0]           lat_tot,
    input  logic [CNT_W-1:0]           lat_cnt,
    input  logic [CNT_W-1:0]           lat_max,
    input  logic [OCC_W-1:0]           occ,
    output logic [CNT_W-1:0]           rdata
);

    localparam int QW = ADDR_W - OFF_BITS;
    localparam logic [QW-1:0] LAT_BLK = QW'(NQ);

    logic [QW-1:0]       blk;
    logic [OFF_BITS-1:0] off;
    logic [CNT_W-1:0]    word;

    assign blk = addr[ADDR_W-1:OFF_BITS];
    assign off = addr[OFF_BITS-1:0];

    always_comb begin
        word = '0;
        for (int i = 0; i < NQ; i++) begin
            if (blk == QW'(i)) begin
                case (off)
                    3'd0:    word = CNT_W'(lvl[i]);
                    3'd1:    word = e_tot[i];
                    3'd2:    word = e_per[i];
                    3'd3:    word = e_max[i];
                    3'd4:    word = f_tot[i];
                    3'd5:    word = f_per[i];
                    3'd6:    word = f_max[i];
                    default: word = '0;
                endcase
            end
        end
        if (blk == LAT_BLK) begin
            case (off)
                3'd0:    word = lat_tot;
                3'd1:    word = lat_cnt;
                3'd2:    word = lat_max;
                3'd3:    word = CNT_W'(occ);
                default: word = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= word;
    end

endmodule

// File: rtl/fifo_perf_monitor.sv
module fifo_perf_monitor
    import fpm_pkg::*;
#(
    parameter int NQ       = 2,
    parameter int LVL_W    = 5,
    parameter int CNT_W    = 16,
    parameter int TS_DEPTH = 4,
    localparam int ADDR_W  = $clog2((NQ + 2) * BLK_WORDS),
    localparam int OCC_W   = $clog2(TS_DEPTH) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NQ*LVL_W-1:0]   q_level,
    input  logic [NQ-1:0]         q_empty,
    input  logic [NQ-1:0]         q_full,
    input  logic                  req_fire,
    input  logic                  rsp_fire,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    output logic [CNT_W-1:0]      bus_rdata
);

    logic                       clr_hit;
    logic [NQ-1:0][LVL_W-1:0]   lvl_a;
    logic [NQ-1:0][CNT_W-1:0]   e_tot_a;
    logic [NQ-1:0][CNT_W-1:0]   e_per_a;
    logic [NQ-1:0][CNT_W-1:0]   e_max_a;
    logic [NQ-1:0][CNT_W-1:0]   f_tot_a;
    logic [NQ-1:0][CNT_W-1:0]   f_per_a;
    logic [NQ-1:0][CNT_W-1:0]   f_max_a;
    logic [CNT_W-1:0]           lat_tot_w;
    logic [CNT_W-1:0]           lat_cnt_w;
    logic [CNT_W-1:0]           lat_max_w;
    logic [OCC_W-1:0]           occ_w;

    assign clr_hit = bus_wr && (bus_addr == {ADDR_W{1'b1}});
    assign lvl_a   = q_level;

    for (genvar g = 0; g < NQ; g++) begin : g_q
        fpm_queue_stats #(.CNT_W(CNT_W)) u_qs (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr_hit),
            .is_empty (q_empty[g]),
            .is_full  (q_full[g]),
            .e_tot    (e_tot_a[g]),
            .e_per    (e_per_a[g]),
            .e_max    (e_max_a[g]),
            .f_tot    (f_tot_a[g]),
            .f_per    (f_per_a[g]),
            .f_max    (f_max_a[g])
        );
    end

    fpm_latency #(.CNT_W(CNT_W), .DEPTH(TS_DEPTH)) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_hit),
        .req     (req_fire),
        .rsp     (rsp_fire),
        .lat_tot (lat_tot_w),
        .lat_cnt (lat_cnt_w),
        .lat_max (lat_max_w),
        .occ     (occ_w)
    );

    fpm_readout #(
        .NQ(NQ), .LVL_W(LVL_W), .CNT_W(CNT_W), .OCC_W(OCC_W), .ADDR_W(ADDR_W)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (bus_rd),
        .addr    (bus_addr),
        .lvl     (lvl_a),
        .e_tot   (e_tot_a),
        .e_per   (e_per_a),
        .e_max   (e_max_a),
        .f_tot   (f_tot_a),
        .f_per   (f_per_a),
        .f_max   (f_max_a),
        .lat_tot (lat_tot_w),
        .lat_cnt (lat_cnt_w),
        .lat_max (lat_max_w),
        .occ     (occ_w),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/fpm_checker.sv
module fpm_checker #(
    parameter int CNT_W = 16,
    parameter int DEPTH = 4,
    localparam int OCC_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_rd,
    input logic [CNT_W-1:0] bus_rdata,
    input logic             clr,
    input logic             rsp_fire,
    input logic [CNT_W-1:0] e_tot0,
    input logic [CNT_W-1:0] e_max0,
    input logic [CNT_W-1:0] lat_cnt,
    input logic [OCC_W-1:0] occ
);

    localparam logic [CNT_W-1:0] CMAX    = {CNT_W{1'b1}};
    localparam logic [OCC_W-1:0] OCC_LIM = OCC_W'(DEPTH);

    // R10: read data only changes after a read strobe
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R9: clear zeros statistics at the clear edge
    a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (e_tot0 == '0) && (lat_cnt == '0));

    // R3 / R8: totals never go down without a clear
    a_r3_total_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> e_tot0 >= $past(e_tot0));

    // R5: the longest period never exceeds the accumulated total
    a_r5_max_within_total: assert property (@(posedge clk) disable iff (!rst_n)
        e_max0 <= e_tot0);

    // R7: outstanding count bounded by store depth
    a_r7_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_LIM);

    // R6 / R8: an accepted response advances the count by one unless saturated
    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fire && (occ != '0) && !clr) |=>
            (lat_cnt == $past(lat_cnt) + 1'b1) || ($past(lat_cnt) == CMAX));

    // R7: a response with nothing outstanding leaves the count alone
    a_r7_orphan_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fire && (occ == '0) && !clr) |=> $stable(lat_cnt));

endmodule

bind fifo_perf_monitor fpm_checker #(.CNT_W(CNT_W), .DEPTH(TS_DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .clr       (clr_hit),
    .rsp_fire  (rsp_fire),
    .e_tot0    (e_tot_a[0]),
    .e_max0    (e_max_a[0]),
    .lat_cnt   (lat_cnt_w),
    .occ       (occ_w)
);

// File: tb/sim_fifo_perf_monitor.sv
`timescale 1ns/1ps
module sim_fifo_perf_monitor;

    localparam int NQ = 2;
    localparam int LW = 5;
    localparam int CW = 8;
    localparam int TD = 4;
    localparam int AW = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NQ*LW-1:0] q_level = '0;
    logic [NQ-1:0]  q_empty = '0;
    logic [NQ-1:0]  q_full = '0;
    logic           req_fire = 1'b0;
    logic           rsp_fire = 1'b0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [CW-1:0]  bus_rdata;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fifo_perf_monitor #(.NQ(NQ), .LVL_W(LW), .CNT_W(CW), .TS_DEPTH(TD)) u0 (
        .clk(clk), .rst_n(rst_n), .q_level(q_level), .q_empty(q_empty),
        .q_full(q_full), .req_fire(req_fire), .rsp_fire(rsp_fire),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_rdata(bus_rdata)
    );

    // entry: empty, full, edges, then expected e_tot e_per e_max f_tot f_per f_max
    localparam int TV [0:6][0:8] = '{
        '{1, 0, 5,   5, 1, 5,  0, 0, 0},
        '{0, 1, 3,   5, 1, 5,  3, 1, 3},
        '{1, 0, 2,   7, 2, 5,  3, 1, 3},
        '{1, 1, 4,  11, 3, 5,  3, 1, 3},
        '{0, 1, 6,  11, 3, 5,  9, 2, 6},
        '{0, 0, 7,  11, 3, 5,  9, 2, 6},
        '{1, 0, 8,  19, 4, 8,  9, 2, 6}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic rd_word(input int a, output int v);
        bus_rd = 1'b1;
        bus_addr = AW'(a);
        @(negedge clk);
        bus_rd = 1'b0;
        v = int'(bus_rdata);
    endtask

    task automatic rd_chk(input string tag, input int a, input int exp);
        int v;
        rd_word(a, v);
        chk(tag, v, exp);
    endtask

    task automatic step(input bit rq, input bit rs);
        req_fire = rq;
        rsp_fire = rs;
        @(negedge clk);
        req_fire = 1'b0;
        rsp_fire = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        bus_wr = 1'b1;
        bus_addr = '1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 rdata after reset", int'(bus_rdata), 0);
        rd_chk("R1 q0 empty total", 1, 0);
        rd_chk("R1 latency count", 17, 0);

        // R2 live level
        q_level = {5'd7, 5'd13};
        rd_chk("R2 q0 level", 0, 13);
        rd_chk("R2 q1 level", 8, 7);

        // R3 R4 R5 table walk on queue 0
        for (int i = 0; i < 7; i++) begin
            q_empty[0] = TV[i][0][0];
            q_full[0]  = TV[i][1][0];
            idle(TV[i][2]);
            q_empty[0] = 1'b0;
            q_full[0]  = 1'b0;
            rd_chk($sformatf("R3 row%0d empty total", i), 1, TV[i][3]);
            rd_chk($sformatf("R3 row%0d empty periods", i), 2, TV[i][4]);
            rd_chk($sformatf("R5 row%0d empty max", i), 3, TV[i][5]);
            rd_chk($sformatf("R4 row%0d full total", i), 4, TV[i][6]);
            rd_chk($sformatf("R4 row%0d full periods", i), 5, TV[i][7]);
            rd_chk($sformatf("R5 row%0d full max", i), 6, TV[i][8]);
        end

        // R6 single request, latency 3
        step(1, 0); idle(2); step(0, 1);
        rd_chk("R6 total single", 16, 3);
        rd_chk("R6 count single", 17, 1);
        rd_chk("R6 max single", 18, 3);

        // R6 two back-to-back requests, in-order, latency 6 each
        step(1, 0); step(1, 0); idle(4); step(0, 1); step(0, 1);
        rd_chk("R6 total pair", 16, 15);
        rd_chk("R6 count pair", 17, 3);
        rd_chk("R6 max pair", 18, 6);

        // R7 overfill: fifth request dropped
        for (int i = 0; i < 5; i++) step(1, 0);
        rd_chk("R7 outstanding capped", 19, 4);
        for (int i = 0; i < 5; i++) step(0, 1);
        rd_chk("R7 count after drain", 17, 7);
        rd_chk("R7 total after drain", 16, 39);
        rd_chk("R7 outstanding empty", 19, 0);

        // R7 orphan response ignored
        step(0, 1);
        rd_chk("R7 orphan count unchanged", 17, 7);

        // R7 simultaneous with nothing outstanding: push only
        step(1, 1); idle(1); step(0, 1);
        rd_chk("R7 simultaneous count", 17, 8);
        rd_chk("R7 simultaneous total", 16, 41);
        rd_chk("R6 max unchanged", 18, 6);

        // R8 saturation on queue 1
        q_empty[1] = 1'b1;
        idle(300);
        rd_chk("R8 q1 empty total saturates", 9, 255);
        rd_chk("R8 q1 empty max saturates", 11, 255);
        rd_chk("R8 q1 empty periods", 10, 1);

        // R9 clear keeps outstanding timestamp, restarts period
        step(1, 0); clear_all(); idle(1); step(0, 1);
        rd_chk("R9 latency count after clear", 17, 1);
        rd_chk("R9 latency total after clear", 16, 3);
        rd_chk("R9 q0 empty total cleared", 1, 0);
        rd_chk("R9 q1 period restarted", 10, 1);
        q_empty[1] = 1'b0;

        // R10 unmapped words and hold
        rd_chk("R10 unmapped queue word", 7, 0);
        rd_chk("R10 level read before hold", 0, 13);
        q_level = {5'd7, 5'd2};
        idle(2);
        chk("R10 rdata held", int'(bus_rdata), 13);
        rd_chk("R10 unmapped latency word", 20, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule